// File: doc/BRIEF.md
# Lane-Partitioned Integer Reservation Station

This block is the integer scheduling buffer that sits between dispatch and three ALUs. It is split into three lanes of eight slots each. Every lane is wired to exactly one ALU. The dispatch port carries a lane number that was chosen upstream, so the buffer makes no lane choice of its own. Each slot holds one macro-op. A macro-op can have an address part, an ALU part, or both. The two parts wait on their operands and issue as separate events, but they share the slot until both are gone.

Operand readiness is kept as one bit per source. A bit is set either at dispatch or by a result tag broadcast on the writeback bus. In every cycle each lane offers at most one part to its ALU, and it picks from its own slots only. A lane that holds several ready parts therefore queues them, even when the other ALUs have nothing to do. A flush input empties the whole buffer. Each lane reports a full flag so that dispatch can hold back.

Top module: `lane_rs`

## Requirements
- R1: A macro-op dispatched with `dispLane` = L (0, 1 or 2) appears only on issue port L. A `dispLane` value of 3 is not accepted.
- R2: Each lane asserts at most one issue per cycle. Ready parts held in one lane never appear on another lane's port, even while those ports are idle.
- R3: Among the ready parts of a lane, the part whose macro-op was dispatched earliest issues first, whatever slot index it holds.
- R4: Each part has its own readiness rule. The address part (`dispNeedAddr`) is ready once source A is ready, and issues with `issueIsAlu` = 0. The ALU part (`dispNeedAlu`) is ready once sources A and B are both ready, and issues with `issueIsAlu` = 1. When both parts of one slot are ready, the address part goes first.
- R5: A slot stays occupied until every requested part has issued. It is released at the clock edge where its last part issues.
- R6: A writeback broadcast (`wbValid`, `wbTag`) marks as ready every stored source whose tag matches, in all lanes, at the same clock edge.
- R7: If a broadcast in the dispatch cycle matches a dispatched source tag, that source is stored as ready.
- R8: `laneFull[L]` is 1 exactly when all eight slots of lane L are occupied. A dispatch to a full lane is dropped.
- R9: A flush empties every slot at the next edge. A dispatch presented in the same cycle as a flush is dropped, and no issue is asserted during the flush cycle.
- R10: After reset, all slots are empty. `issueValid` and `laneFull` are all zero.
- R11: A dispatch takes the lowest-numbered free slot of its lane. `issueEntry` reports the slot of the issuing part.
- R12: A part that is ready on arrival is shown on its issue port in the cycle after the dispatch edge. It leaves at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Empty every slot |
| dispValid | input | 1 | Dispatch request |
| dispLane | input | 2 | Target lane |
| dispOpTag | input | 8 | Macro-op tag |
| dispNeedAddr | input | 1 | Macro-op has an address part |
| dispNeedAlu | input | 1 | Macro-op has an ALU part |
| dispSrcATag | input | 6 | Source A tag |
| dispSrcARdy | input | 1 | Source A already ready |
| dispSrcBTag | input | 6 | Source B tag |
| dispSrcBRdy | input | 1 | Source B already ready |
| wbValid | input | 1 | Writeback broadcast valid |
| wbTag | input | 6 | Writeback result tag |
| laneFull | output | 3 | Per-lane full flag |
| issueValid | output | 3 | Per-lane issue strobe |
| issueIsAlu | output | 3 | 1 = ALU part, 0 = address part |
| issueOpTag | output | 3x8 | Tag of the issuing macro-op |
| issueEntry | output | 3x3 | Slot index of the issuing part |

## Verification
The bench uses the default build: three lanes of eight slots, 6-bit source tags and 8-bit op tags. At this size one lane can be filled completely, and the rejected ninth dispatch and the in-order drain can both be watched. Age ordering is checked against slot order by reusing a freed low slot for a younger op. A single broadcast is shown waking all three lanes at once, and several ready parts in one lane are shown to queue while the other lanes stay empty.

// File: rtl/lane_rs_pkg.sv
package lane_rs_pkg;
  localparam int NumLanes  = 3;
  localparam int LaneDepth = 8;
  localparam int SrcTagW   = 6;
  localparam int OpTagW    = 8;
  localparam int IdxW      = $clog2(LaneDepth);
  localparam int LaneW     = $clog2(NumLanes + 1);

  typedef struct packed {
    logic            wrEn;
    logic [IdxW-1:0] wrIdx;
    logic [IdxW-1:0] rdIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/lane_rs_data.sv
module lane_rs_data
  import lane_rs_pkg::*;
(
  input  logic                 clk,
  input  ctrlStrobes_t         strobes,
  input  logic [OpTagW-1:0]    dispOpTag,
  input  logic [SrcTagW-1:0]   dispSrcATag,
  input  logic [SrcTagW-1:0]   dispSrcBTag,
  input  logic                 wbValid,
  input  logic [SrcTagW-1:0]   wbTag,
  output logic [LaneDepth-1:0] wakeA,
  output logic [LaneDepth-1:0] wakeB,
  output logic [OpTagW-1:0]    rdOpTag
);
  logic [OpTagW-1:0]  opTagQ   [LaneDepth];
  logic [SrcTagW-1:0] srcATagQ [LaneDepth];
  logic [SrcTagW-1:0] srcBTagQ [LaneDepth];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      opTagQ[strobes.wrIdx]   <= dispOpTag;
      srcATagQ[strobes.wrIdx] <= dispSrcATag;
      srcBTagQ[strobes.wrIdx] <= dispSrcBTag;
    end
  end

  // tag compare per slot against the writeback bus
  for (genvar e = 0; e < LaneDepth; e++) begin : g_cam
    assign wakeA[e] = wbValid && (srcATagQ[e] == wbTag);
    assign wakeB[e] = wbValid && (srcBTagQ[e] == wbTag);
  end

  assign rdOpTag = opTagQ[strobes.rdIdx];
endmodule

// File: rtl/lane_rs_ctrl.sv
module lane_rs_ctrl
  import lane_rs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 allocReq,
  input  logic                 needAddr,
  input  logic                 needAlu,
  input  logic                 rdyAIn,
  input  logic                 rdyBIn,
  input  logic [LaneDepth-1:0] wakeA,
  input  logic [LaneDepth-1:0] wakeB,
  output ctrlStrobes_t         strobes,
  output logic                 laneFull,
  output logic                 issueValid,
  output logic                 issueIsAlu
);
  logic [LaneDepth-1:0] validQ, addrPendQ, aluPendQ, rdyAQ, rdyBQ;
  logic [LaneDepth-1:0] olderQ [LaneDepth];  // olderQ[j][i]: slot j older than slot i
  logic [LaneDepth-1:0] addrCand, aluCand, cand, grant;
  logic [IdxW-1:0]      pickIdx, freeIdx;
  logic                 fire, alloc, pickAlu;

  assign addrCand = validQ & addrPendQ & rdyAQ;
  assign aluCand  = validQ & aluPendQ & rdyAQ & rdyBQ;
  assign cand     = addrCand | aluCand;

  always_comb begin
    grant = '0;
    for (int i = 0; i < LaneDepth; i++) begin
      grant[i] = cand[i];
      for (int j = 0; j < LaneDepth; j++)
        if (cand[j] && olderQ[j][i]) grant[i] = 1'b0;
    end
  end

  always_comb begin
    pickIdx = '0;
    for (int i = 0; i < LaneDepth; i++)
      if (grant[i]) pickIdx = IdxW'(i);
  end

  always_comb begin
    freeIdx = '0;
    for (int i = LaneDepth - 1; i >= 0; i--)
      if (!validQ[i]) freeIdx = IdxW'(i);
  end

  assign laneFull   = &validQ;
  assign fire       = (|cand) && !flush;
  assign pickAlu    = !addrCand[pickIdx];
  assign alloc      = allocReq && !laneFull && !flush && (needAddr || needAlu);
  assign issueValid = fire;
  assign issueIsAlu = pickAlu;

  assign strobes.wrEn  = alloc;
  assign strobes.wrIdx = freeIdx;
  assign strobes.rdIdx = pickIdx;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      validQ    <= '0;
      addrPendQ <= '0;
      aluPendQ  <= '0;
      rdyAQ     <= '0;
      rdyBQ     <= '0;
    end else begin
      for (int i = 0; i < LaneDepth; i++) begin
        if (alloc && freeIdx == IdxW'(i)) begin
          validQ[i]    <= 1'b1;
          addrPendQ[i] <= needAddr;
          aluPendQ[i]  <= needAlu;
          rdyAQ[i]     <= rdyAIn;
          rdyBQ[i]     <= rdyBIn;
        end else begin
          rdyAQ[i] <= rdyAQ[i] | wakeA[i];
          rdyBQ[i] <= rdyBQ[i] | wakeB[i];
          if (fire && pickIdx == IdxW'(i)) begin
            if (pickAlu) begin
              aluPendQ[i] <= 1'b0;
              if (!addrPendQ[i]) validQ[i] <= 1'b0;
            end else begin
              addrPendQ[i] <= 1'b0;
              if (!aluPendQ[i]) validQ[i] <= 1'b0;
            end
          end
        end
      end
    end
  end

  // age matrix: a new slot is younger than every other slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < LaneDepth; j++) olderQ[j] <= '0;
    end else if (alloc) begin
      for (int j = 0; j < LaneDepth; j++) begin
        if (IdxW'(j) == freeIdx) olderQ[j] <= '0;
        else olderQ[j][freeIdx] <= 1'b1;
      end
    end
  end

  assert_one_pick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_part_retired_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !pickAlu) |=> !(validQ[$past(pickIdx)] && addrPendQ[$past(pickIdx)]));

  assert_single_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(flush)) |-> ($countones($past(validQ) & ~validQ) <= 1));

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    alloc |-> !validQ[freeIdx]);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validQ == '0));
endmodule

// File: rtl/lane_rs.sv
module lane_rs
  import lane_rs_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                flush,
  input  logic                                dispValid,
  input  logic [LaneW-1:0]                    dispLane,
  input  logic [OpTagW-1:0]                   dispOpTag,
  input  logic                                dispNeedAddr,
  input  logic                                dispNeedAlu,
  input  logic [SrcTagW-1:0]                  dispSrcATag,
  input  logic                                dispSrcARdy,
  input  logic [SrcTagW-1:0]                  dispSrcBTag,
  input  logic                                dispSrcBRdy,
  input  logic                                wbValid,
  input  logic [SrcTagW-1:0]                  wbTag,
  output logic [NumLanes-1:0]                 laneFull,
  output logic [NumLanes-1:0]                 issueValid,
  output logic [NumLanes-1:0]                 issueIsAlu,
  output logic [NumLanes-1:0][OpTagW-1:0]     issueOpTag,
  output logic [NumLanes-1:0][IdxW-1:0]       issueEntry
);
  logic rdyA, rdyB;

  // same-cycle bypass of a broadcast into the dispatched sources
  assign rdyA = dispSrcARdy || (wbValid && wbTag == dispSrcATag);
  assign rdyB = dispSrcBRdy || (wbValid && wbTag == dispSrcBTag);

  for (genvar l = 0; l < NumLanes; l++) begin : g_lane
    ctrlStrobes_t         strobes;
    logic [LaneDepth-1:0] wakeA, wakeB;
    logic                 allocReq;

    assign allocReq = dispValid && (dispLane == LaneW'(l));

    lane_rs_ctrl u_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .flush      (flush),
      .allocReq   (allocReq),
      .needAddr   (dispNeedAddr),
      .needAlu    (dispNeedAlu),
      .rdyAIn     (rdyA),
      .rdyBIn     (rdyB),
      .wakeA      (wakeA),
      .wakeB      (wakeB),
      .strobes    (strobes),
      .laneFull   (laneFull[l]),
      .issueValid (issueValid[l]),
      .issueIsAlu (issueIsAlu[l])
    );

    lane_rs_data u_data (
      .clk         (clk),
      .strobes     (strobes),
      .dispOpTag   (dispOpTag),
      .dispSrcATag (dispSrcATag),
      .dispSrcBTag (dispSrcBTag),
      .wbValid     (wbValid),
      .wbTag       (wbTag),
      .wakeA       (wakeA),
      .wakeB       (wakeB),
      .rdOpTag     (issueOpTag[l])
    );

    assign issueEntry[l] = strobes.rdIdx;
  end

  assert_flush_no_issue_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (issueValid == '0));
endmodule

// File: tb/tb_lane_rs.sv
`timescale 1ns/1ps
module tb_lane_rs;
  import lane_rs_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic dispValid = 1'b0;
  logic [LaneW-1:0] dispLane = '0;
  logic [OpTagW-1:0] dispOpTag = '0;
  logic dispNeedAddr = 1'b0, dispNeedAlu = 1'b0;
  logic [SrcTagW-1:0] dispSrcATag = '0, dispSrcBTag = '0;
  logic dispSrcARdy = 1'b0, dispSrcBRdy = 1'b0;
  logic wbValid = 1'b0;
  logic [SrcTagW-1:0] wbTag = '0;
  logic [NumLanes-1:0] laneFull, issueValid, issueIsAlu;
  logic [NumLanes-1:0][OpTagW-1:0] issueOpTag;
  logic [NumLanes-1:0][IdxW-1:0] issueEntry;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lane_rs dut (
    .clk(clk), .rstN(rstN), .flush(flush), .dispValid(dispValid), .dispLane(dispLane),
    .dispOpTag(dispOpTag), .dispNeedAddr(dispNeedAddr), .dispNeedAlu(dispNeedAlu),
    .dispSrcATag(dispSrcATag), .dispSrcARdy(dispSrcARdy), .dispSrcBTag(dispSrcBTag),
    .dispSrcBRdy(dispSrcBRdy), .wbValid(wbValid), .wbTag(wbTag), .laneFull(laneFull),
    .issueValid(issueValid), .issueIsAlu(issueIsAlu), .issueOpTag(issueOpTag),
    .issueEntry(issueEntry)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chkIss(string req, int lane, bit expV, int expTag = 0, bit expAlu = 1'b0,
                        int expEntry = 0);
    chk(req, int'(issueValid[lane]), int'(expV));
    if (expV) begin
      chk(req, int'(issueOpTag[lane]), expTag);
      chk(req, int'(issueIsAlu[lane]), int'(expAlu));
      chk(req, int'(issueEntry[lane]), expEntry);
    end
  endtask

  task automatic disp(int lane, int op, bit nAddr, bit nAlu, int aTag, bit aRdy, int bTag,
                      bit bRdy, bit doWb = 1'b0, int wTag = 0);
    dispValid = 1'b1;
    dispLane = LaneW'(lane);
    dispOpTag = OpTagW'(op);
    dispNeedAddr = nAddr;
    dispNeedAlu = nAlu;
    dispSrcATag = SrcTagW'(aTag);
    dispSrcARdy = aRdy;
    dispSrcBTag = SrcTagW'(bTag);
    dispSrcBRdy = bRdy;
    wbValid = doWb;
    wbTag = SrcTagW'(wTag);
    @(negedge clk);
    dispValid = 1'b0;
    wbValid = 1'b0;
  endtask

  task automatic bcast(int tag);
    wbValid = 1'b1;
    wbTag = SrcTagW'(tag);
    @(negedge clk);
    wbValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R10: reset state
    chk("R10 issueValid", int'(issueValid), 0);
    chk("R10 laneFull", int'(laneFull), 0);
    rstN = 1'b1;
    idle(1);
    chk("R10 issueValid after release", int'(issueValid), 0);

    // R1 R11 R12: lane binding and next-cycle issue
    for (int l = 0; l < NumLanes; l++) begin
      disp(l, 'h10 + l, 1'b0, 1'b1, 1, 1'b1, 1, 1'b1);
      chk("R1 only own port", int'(issueValid), 1 << l);
      chkIss("R12 issue after dispatch", l, 1'b1, 'h10 + l, 1'b1, 0);
      idle(1);
      chk("R12 gone after issue", int'(issueValid), 0);
    end
    disp(3, 'h1F, 1'b0, 1'b1, 1, 1'b1, 1, 1'b1);
    chk("R1 lane 3 not accepted", int'(issueValid), 0);

    // R2 R3: three ready ops in lane 0 drain one per cycle, oldest first
    for (int k = 0; k < 3; k++) disp(0, 'h20 + k, 1'b0, 1'b1, 9, 1'b0, 0, 1'b1);
    chk("R2 nothing before wakeup", int'(issueValid), 0);
    bcast(9);
    for (int k = 0; k < 3; k++) begin
      chk("R2 only lane 0 issues", int'(issueValid), 1);
      chkIss("R3 in age order", 0, 1'b1, 'h20 + k, 1'b1, k);
      idle(1);
    end
    chk("R2 lane drained", int'(issueValid), 0);

    // R3 R11: younger op in a lower slot waits for the older one
    disp(2, 'h31, 1'b0, 1'b1, 3, 1'b0, 0, 1'b1);
    disp(2, 'h32, 1'b0, 1'b1, 7, 1'b0, 0, 1'b1);
    bcast(3);
    chkIss("R6 wake first", 2, 1'b1, 'h31, 1'b1, 0);
    idle(1);
    chkIss("R3 waiting", 2, 1'b0);
    disp(2, 'h33, 1'b0, 1'b1, 7, 1'b0, 0, 1'b1);
    chkIss("R3 still waiting", 2, 1'b0);
    bcast(7);
    chkIss("R3 older in slot 1 first", 2, 1'b1, 'h32, 1'b1, 1);
    idle(1);
    chkIss("R11 younger reused slot 0", 2, 1'b1, 'h33, 1'b1, 0);
    idle(1);
    chkIss("R3 lane 2 empty", 2, 1'b0);

    // R4: both parts ready, address part first
    disp(1, 'h40, 1'b1, 1'b1, 1, 1'b1, 1, 1'b1);
    chkIss("R4 address part first", 1, 1'b1, 'h40, 1'b0, 0);
    idle(1);
    chkIss("R4 ALU part second", 1, 1'b1, 'h40, 1'b1, 0);
    idle(1);
    chkIss("R5 released", 1, 1'b0);

    // R4 R5: ALU part waits for B while the slot stays held
    disp(1, 'h41, 1'b1, 1'b1, 1, 1'b1, 5, 1'b0);
    chkIss("R4 address needs only A", 1, 1'b1, 'h41, 1'b0, 0);
    idle(1);
    chkIss("R4 ALU part waits on B", 1, 1'b0);
    disp(1, 'h42, 1'b0, 1'b1, 6, 1'b0, 0, 1'b1);
    chkIss("R5 held slot", 1, 1'b0);
    bcast(5);
    chkIss("R5 half-done slot kept", 1, 1'b1, 'h41, 1'b1, 0);
    idle(1);
    bcast(6);
    chkIss("R5 new op went to slot 1", 1, 1'b1, 'h42, 1'b1, 1);
    idle(1);
    chkIss("R5 lane 1 empty", 1, 1'b0);

    // R8: fill lane 1, reject the ninth, drain in order
    for (int k = 0; k < LaneDepth; k++) begin
      if (k == LaneDepth - 1) chk("R8 not full at 7", int'(laneFull), 0);
      disp(1, 'h50 + k, 1'b0, 1'b1, 11, 1'b0, 0, 1'b1);
    end
    chk("R8 full flag", int'(laneFull), 2);
    disp(1, 'h5F, 1'b0, 1'b1, 11, 1'b0, 0, 1'b1);
    chk("R8 still full", int'(laneFull), 2);
    bcast(11);
    for (int k = 0; k < LaneDepth; k++) begin
      chkIss("R8 drain", 1, 1'b1, 'h50 + k, 1'b1, k);
      idle(1);
      if (k == 0) chk("R8 full clears", int'(laneFull), 0);
    end
    chkIss("R8 dropped op never issues", 1, 1'b0);

    // R6: one broadcast wakes all lanes at once
    for (int l = 0; l < NumLanes; l++) disp(l, 'h60 + l, 1'b0, 1'b1, 0, 1'b1, 12, 1'b0);
    chk("R6 before broadcast", int'(issueValid), 0);
    bcast(12);
    chk("R6 all lanes", int'(issueValid), 7);
    for (int l = 0; l < NumLanes; l++) chkIss("R6 tags", l, 1'b1, 'h60 + l, 1'b1, 0);
    idle(1);

    // R7: dispatch-cycle bypass
    disp(0, 'h70, 1'b0, 1'b1, 13, 1'b0, 0, 1'b1, 1'b1, 14);
    chkIss("R7 mismatched tag", 0, 1'b0);
    disp(0, 'h71, 1'b0, 1'b1, 14, 1'b0, 0, 1'b1, 1'b1, 14);
    chkIss("R7 bypass", 0, 1'b1, 'h71, 1'b1, 1);
    idle(1);
    bcast(13);
    chkIss("R7 late wake", 0, 1'b1, 'h70, 1'b1, 0);
    idle(1);

    // R9: flush empties all lanes and drops a concurrent dispatch
    disp(0, 'h80, 1'b0, 1'b1, 15, 1'b0, 0, 1'b1);
    disp(2, 'h81, 1'b0, 1'b1, 15, 1'b0, 0, 1'b1);
    flush = 1'b1;
    #1;
    chk("R9 no issue during flush", int'(issueValid), 0);
    disp(1, 'h82, 1'b0, 1'b1, 1, 1'b1, 1, 1'b1);
    flush = 1'b0;
    chk("R9 concurrent dispatch dropped", int'(issueValid), 0);
    bcast(15);
    chk("R9 flushed ops gone", int'(issueValid), 0);
    disp(0, 'h83, 1'b0, 1'b1, 1, 1'b1, 1, 1'b1);
    chkIss("R9 slot 0 free after flush", 0, 1'b1, 'h83, 1'b1, 0);
    idle(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule